// File: doc/BRIEF.md
# Supervisory Reset Pulse Sequencer

The sequencer merges the reset requests of a supervisory subsystem into a single active-low reset output with a guaranteed minimum hold time. Three requests are levels: two undervoltage flags, already converted to logic by comparators elsewhere, and a manual-reset pin. The fourth is a one-cycle fault strobe from a watchdog. The three asynchronous levels pass through a two-flop synchronizer. The manual-reset pin must also stay low for a qualification time before it counts, so switch bounce and short glitches are ignored.

Reset holds for `HOLD_CYCLES` clock cycles after the last request goes away. A new request at any point in that window restarts it. A lone watchdog strobe therefore gives one pulse exactly `HOLD_CYCLES` long. The same counter runs after power-on, so the output leaves reset asserted for one full hold. A separate status output tells the watchdog blocks that reset is in force, so they can keep their own timers cleared. The hold length and the manual-reset qualification time are separate parameters, and both are independent of any watchdog period.

Top module: `supv_reset_seq`

## Requirements
- R1: A high level on `uv_main_i` or `uv_aux_i`, applied between clock edges, drives `reset_n_o` low after the third following rising edge. Reset stays low for as long as either flag is high.
- R2: When `mr_n_i` is low for L whole clock cycles, reset asserts only if L >= `MR_QUAL_CYCLES`. It then goes low after rising edge 3 + `MR_QUAL_CYCLES`, counted from the first low cycle. Shorter lows leave `reset_n_o` high.
- R3: After the last undervoltage flag falls, `reset_n_o` returns high after the (2 + `HOLD_CYCLES`)-th rising edge.
- R4: After a qualified manual-reset low returns high, `reset_n_o` returns high after the (3 + `HOLD_CYCLES`)-th rising edge.
- R5: A one-cycle `wdog_fault_i` strobe, sampled with no synchronizer, drives `reset_n_o` low for exactly `HOLD_CYCLES` cycles, starting after the edge that samples it.
- R6: A request that arrives while reset is being held restarts the hold. A second strobe k cycles into a strobe-started pulse gives a total low time of k + `HOLD_CYCLES` cycles.
- R7: While `rst_n` is low, `reset_n_o` is low. After `rst_n` is released, it stays low for `HOLD_CYCLES` cycles, counting the cycle of release.
- R8: `reset_active_o` is high exactly when `reset_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| uv_main_i | input | 1 | Main supply undervoltage flag, asynchronous, active high |
| uv_aux_i | input | 1 | Auxiliary rail undervoltage flag, asynchronous, active high |
| mr_n_i | input | 1 | Manual-reset pin, asynchronous, active low |
| wdog_fault_i | input | 1 | One-cycle watchdog fault strobe, synchronous to `clk` |
| reset_n_o | output | 1 | Merged system reset, active low |
| reset_active_o | output | 1 | High while the merged reset is asserted |

## Verification
The properties treat `wdog_fault_i` as already synchronous to `clk`, so it has no settling time. They also assume the asynchronous levels change at most once per cycle, which lets a synchronized sample stand for the pin. The stimulus changes every input on the falling clock edge. Each manual-reset low is a whole number of cycles long, so its length is known exactly when it reaches the qualification counter. Glitch lengths are swept from one cycle up to two beyond the qualification time. Retrigger offsets are swept across the whole hold window.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Bits needed to hold the values 0..max_val.
  function automatic int unsigned width_for(input int unsigned max_val);
    int unsigned w;
    w = $clog2(max_val + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Saturating increment against an integer ceiling.
  function automatic int unsigned sat_next(input int unsigned cur, input int unsigned ceil);
    return (cur >= ceil) ? ceil : cur + 1;
  endfunction

  // Asynchronous request levels, in the order the synchronizer carries them.
  typedef struct packed {
    logic uv_main;
    logic uv_aux;
    logic mr_n;
  } supv_async_t;

  localparam supv_async_t ASYNC_IDLE = '{uv_main: 1'b0, uv_aux: 1'b0, mr_n: 1'b1};

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= g_stage[s-1].q;
      end
    end
  end

  assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/supv_mr_qual.sv
module supv_mr_qual
  import supv_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_n_s,
  output logic mr_req
);

  localparam int unsigned CW = width_for(QUAL_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] streak_q;
  logic          req_q;
  logic          streak_full;

  assign streak_full = (streak_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak_q <= '0;
      req_q    <= 1'b0;
    end else if (mr_n_s) begin
      streak_q <= '0;
      req_q    <= 1'b0;
    end else begin
      if (!streak_full) streak_q <= streak_q + CW'(1);
      req_q <= req_q | streak_full;
    end
  end

  assign mr_req = req_q;

endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer
  import supv_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);

  localparam int unsigned HW = width_for(HOLD_CYCLES);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYCLES);

  logic [HW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= HOLD_V;
    else if (load)           left_q <= HOLD_V;
    else if (left_q != '0)   left_q <= left_q - HW'(1);
  end

  assign busy = (left_q != '0);

endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq
  import supv_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 1000,
  parameter int unsigned MR_QUAL_CYCLES = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_main_i,
  input  logic uv_aux_i,
  input  logic mr_n_i,
  input  logic wdog_fault_i,
  output logic reset_n_o,
  output logic reset_active_o
);

  localparam int unsigned AW = $bits(supv_async_t);

  supv_async_t raw;
  supv_async_t synced;
  logic [AW-1:0] synced_bits;

  logic mr_n_s;
  logic mr_req;
  logic level_req;
  logic any_req;
  logic hold_busy;

  assign raw = '{uv_main: uv_main_i, uv_aux: uv_aux_i, mr_n: mr_n_i};

  supv_sync #(
    .WIDTH  (AW),
    .STAGES (SYNC_STAGES),
    .RST_VAL(ASYNC_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw),
    .dout (synced_bits)
  );

  assign synced = supv_async_t'(synced_bits);
  assign mr_n_s = synced.mr_n;

  supv_mr_qual #(
    .QUAL_CYCLES(MR_QUAL_CYCLES)
  ) u_mr_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .mr_n_s(mr_n_s),
    .mr_req(mr_req)
  );

  assign level_req = synced.uv_main | synced.uv_aux | mr_req;
  assign any_req   = level_req | wdog_fault_i;

  supv_hold_timer #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (any_req),
    .busy (hold_busy)
  );

  assign reset_n_o      = ~hold_busy;
  assign reset_active_o = hold_busy;

endmodule

// File: rtl/supv_reset_seq_chk.sv
module supv_reset_seq_chk
  import supv_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 1000,
  parameter int unsigned MR_QUAL_CYCLES = 100
) (
  input logic clk,
  input logic rst_n,
  input logic level_req,
  input logic wdog_fault_i,
  input logic mr_n_s,
  input logic mr_req,
  input logic reset_n_o
);

  localparam int unsigned QW = width_for(HOLD_CYCLES + 1);
  localparam int unsigned SW = width_for(MR_QUAL_CYCLES);

  logic [QW-1:0] quiet_q;
  logic [SW-1:0] low_q;

  // Cycles since the last request of any kind.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          quiet_q <= '0;
    else if (level_req || wdog_fault_i)  quiet_q <= '0;
    else quiet_q <= QW'(sat_next(int'(quiet_q), HOLD_CYCLES + 1));
  end

  // Consecutive synchronized manual-reset low samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_q <= '0;
    else if (mr_n_s) low_q <= '0;
    else low_q <= SW'(sat_next(int'(low_q), MR_QUAL_CYCLES));
  end

  p_level_asserts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level_req |=> !reset_n_o);

  p_mr_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_req) |-> (low_q >= SW'(MR_QUAL_CYCLES)));

  p_release_after_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n_o) |-> (quiet_q == QW'(HOLD_CYCLES)));

  p_mr_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mr_n_s |=> !mr_req);

  p_fault_asserts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_fault_i |=> !reset_n_o);

endmodule

bind supv_reset_seq supv_reset_seq_chk #(
  .HOLD_CYCLES   (HOLD_CYCLES),
  .MR_QUAL_CYCLES(MR_QUAL_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .level_req   (level_req),
  .wdog_fault_i(wdog_fault_i),
  .mr_n_s      (mr_n_s),
  .mr_req      (mr_req),
  .reset_n_o   (reset_n_o)
);

// File: tb/tb_supv_reset_seq.sv
module tb_supv_reset_seq;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6;
  localparam int QUAL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv_main = 1'b0;
  logic uv_aux = 1'b0;
  logic mr_n = 1'b1;
  logic fault = 1'b0;
  logic reset_n;
  logic reset_active;

  int checks = 0;
  int failures = 0;
  int mirror_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supv_reset_seq #(
    .HOLD_CYCLES   (HOLD),
    .MR_QUAL_CYCLES(QUAL)
  ) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .uv_main_i     (uv_main),
    .uv_aux_i      (uv_aux),
    .mr_n_i        (mr_n),
    .wdog_fault_i  (fault),
    .reset_n_o     (reset_n),
    .reset_active_o(reset_active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_high();
    for (int i = 0; i < 200 && !reset_n; i++) step();
    step(); step();
  endtask

  // R8: status mirrors the output on every sampled cycle.
  always @(negedge clk) if (reset_active !== ~reset_n) mirror_bad++;

  task automatic summary();
    check(mirror_bad == 0, "R8 status mirror", mirror_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    int t_first_low;
    int t_first_high;
    // R7: held in reset
    step(); step(); step();
    check(reset_n == 1'b0, "R7 low during rst_n", reset_n, 0);
    check(reset_active == 1'b1, "R8 active during rst_n", reset_active, 1);
    rst_n = 1'b1;
    n = 0;
    while (!reset_n && n < 100) begin n++; step(); end
    check(n == HOLD, "R7 power-on hold", n, HOLD);
    step(); step();

    // R1/R3: each undervoltage flag alone
    for (int f = 0; f < 2; f++) begin
      if (f == 0) uv_main = 1'b1; else uv_aux = 1'b1;
      n = 0;
      do begin step(); n++; end while (reset_n && n < 50);
      check(n == 3, "R1 uv assert latency", n, 3);
      n = 0;
      for (int i = 0; i < 20; i++) begin if (reset_n) n++; step(); end
      check(n == 0, "R1 held while flag high", n, 0);
      uv_main = 1'b0; uv_aux = 1'b0;
      n = 0;
      do begin step(); n++; end while (!reset_n && n < 100);
      check(n == 2 + HOLD, "R3 uv release", n, 2 + HOLD);
      step(); step();
    end

    // R1/R3: overlapping flags, release counts from the later one
    uv_main = 1'b1; step(); step();
    uv_aux = 1'b1; step(); step();
    uv_main = 1'b0;
    n = 0;
    for (int i = 0; i < 3 * HOLD; i++) begin if (reset_n) n++; step(); end
    check(n == 0, "R1 overlap keeps reset", n, 0);
    uv_aux = 1'b0;
    n = 0;
    do begin step(); n++; end while (!reset_n && n < 100);
    check(n == 2 + HOLD, "R3 overlap release", n, 2 + HOLD);
    step(); step();

    // R2/R4: manual-reset low length sweep
    for (int len = 1; len <= QUAL + 2; len++) begin
      t_first_low = -1;
      t_first_high = -1;
      mr_n = 1'b0;
      for (int t = 0; t <= len + HOLD + 12; t++) begin
        if (t == len) mr_n = 1'b1;
        if (!reset_n && t_first_low < 0) t_first_low = t;
        if (reset_n && t_first_low >= 0 && t_first_high < 0) t_first_high = t;
        step();
      end
      if (len < QUAL) begin
        check(t_first_low == -1, $sformatf("R2 glitch len=%0d ignored", len), t_first_low, -1);
      end else begin
        check(t_first_low == 3 + QUAL, $sformatf("R2 qualified len=%0d", len), t_first_low, 3 + QUAL);
        check(t_first_high == len + 3 + HOLD, $sformatf("R4 release len=%0d", len),
              t_first_high, len + 3 + HOLD);
      end
      wait_high();
    end

    // R5: single fault strobe
    fault = 1'b1;
    check(reset_n == 1'b1, "R5 high before strobe", reset_n, 1);
    step();
    fault = 1'b0;
    n = 0;
    while (!reset_n && n < 100) begin n++; step(); end
    check(n == HOLD, "R5 pulse width", n, HOLD);
    step(); step();

    // R6: second strobe k cycles into the pulse
    for (int k = 1; k < HOLD; k++) begin
      fault = 1'b1;
      step();
      fault = 1'b0;
      n = 0;
      for (int i = 1; i <= k; i++) begin
        if (!reset_n) n++;
        if (i == k) fault = 1'b1;
        step();
        if (i == k) fault = 1'b0;
      end
      while (!reset_n && n < 200) begin n++; step(); end
      check(n == k + HOLD, $sformatf("R6 retrigger k=%0d", k), n, k + HOLD);
      step(); step();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule